// File: doc/BRIEF.md
# Serial Test-Mode Entry Controller

This block lets a memory device enter its test modes through ordinary control pins, without any high-voltage detection. While the reset-write and write-enable inputs are both held high, a counter advances on the serial write clock. After enough consecutive qualifying clocks, an arming flag is set. Once reset-write has then been seen low, code entry opens. From that point, each serial write clock edge decodes a 4-bit code on the low data inputs, and each code sets a sticky latch for one test mode.

Two special codes close a session. The freeze code shuts code entry but keeps every latched mode. The clear code shuts code entry and drops every mode. After a freeze, the controller can be re-armed with another full hold, and further modes can then be added to those already latched.

The sequencer has three states:
- `ST_IDLE`: not armed. It moves to `ST_ARMED` on the counter's terminal pulse.
- `ST_ARMED`: armed, waiting for reset-write to go low. It moves to `ST_ENTRY` on the first edge where reset-write is sampled low.
- `ST_ENTRY`: codes are decoded. It returns to `ST_IDLE` on the freeze or clear code.

Top module: `tmode_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, the state and every mode latch are cleared. After reset, `entry_en_o` is 0 and `mode_o` is all zero.
- R2: Arming needs ARM_COUNT (default 1024) consecutive edges with `rst_wr_i` and `wr_en_i` both high. An edge where either input is low resets the count to zero, so a hold of ARM_COUNT-1 edges followed by a drop never arms.
- R3: `entry_en_o` rises only after arming completes, and only one edge after an edge where `rst_wr_i` is sampled low. It stays low while `rst_wr_i` remains high after the hold.
- R4: While `entry_en_o` is high, a code value c from 1 to 12 on `code_i` sets `mode_o[c-1]` at that edge. Modes accumulate, so several can be active at once.
- R5: Code 0 sets no mode and changes no output.
- R6: Code 4 (`mode_o[3]`, plate-high) and code 5 (`mode_o[4]`, plate-low) are exclusive. Entering one clears the other, and the most recent one wins.
- R7: Code 13 clears only the test-detect latch (`mode_o[11]`) and leaves all other modes unchanged.
- R8: Code 14 (freeze) drives `entry_en_o` low at that edge and keeps every mode. A later full re-arm reopens entry, the earlier modes are kept, and new modes are added to them.
- R9: Code 15 (clear) drives `entry_en_o` low and clears every mode bit at that edge.
- R10: While `entry_en_o` is low, no code value changes `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial write clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| rst_wr_i | input | 1 | Reset-write control pin |
| wr_en_i | input | 1 | Write-enable control pin |
| code_i | input | 4 | Test code on the low data inputs |
| entry_en_o | output | 1 | Code entry open |
| mode_o | output | 12 | One active-high control line per test mode, bit c-1 for code c |

## Verification
The arming counter is tried with three kinds of hold:
- A hold one edge short, then a drop of write-enable alone. This separates a counter that restarts from one that resumes.
- Two short holds back to back. This exposes a count that is not cleared between holds.
- An exact full hold, with reset-write kept high for one more edge. This shows that entry waits for reset-write to go low.

In one session, the codes are swept so that modes accumulate. This covers the plate pair in both orders, code 0, and the detect-off code. In separate fresh sessions, each code from 1 to 12 is then entered alone, which catches a swapped or merged decode line. The freeze path is re-armed and extended to confirm that latched modes survive. Codes presented while entry is closed, both before arming and after a freeze, must leave the mode lines unchanged.

// File: rtl/tme_pkg.sv
package tme_pkg;

    localparam int CODE_W    = 4;
    localparam int NUM_MODES = 12;

    localparam logic [CODE_W-1:0] CODE_NONE    = 4'd0;
    localparam logic [CODE_W-1:0] CODE_DET_OFF = 4'd13;
    localparam logic [CODE_W-1:0] CODE_FREEZE  = 4'd14;
    localparam logic [CODE_W-1:0] CODE_CLEAR   = 4'd15;

    localparam int IDX_PLATE_HI = 3;
    localparam int IDX_PLATE_LO = 4;
    localparam int IDX_DETECT   = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ENTRY = 2'd2
    } tme_state_e;

endpackage

// File: rtl/tme_arm_counter.sv
module tme_arm_counter #(
    parameter int ARM_COUNT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic qualify,
    output logic arm_pulse
);
    localparam int CW = $clog2(ARM_COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(ARM_COUNT - 1);
    localparam logic [CW-1:0] DONE = CW'(ARM_COUNT);

    logic [CW-1:0] cnt_q;

    // Restart on any break; saturate after completion so the pulse fires once per hold.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!qualify) begin
            cnt_q <= '0;
        end else if (cnt_q != DONE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign arm_pulse = qualify && (cnt_q == LAST);

endmodule

// File: rtl/tme_code_decoder.sv
module tme_code_decoder
    import tme_pkg::*;
(
    input  logic [CODE_W-1:0]    code,
    input  logic                 valid,
    output logic [NUM_MODES-1:0] set_vec,
    output logic                 det_off,
    output logic                 freeze,
    output logic                 clear_all
);
    for (genvar i = 0; i < NUM_MODES; i++) begin : g_line
        assign set_vec[i] = valid && (code == CODE_W'(i + 1));
    end

    assign det_off   = valid && (code == CODE_DET_OFF);
    assign freeze    = valid && (code == CODE_FREEZE);
    assign clear_all = valid && (code == CODE_CLEAR);

endmodule

// File: rtl/tme_latch_bank.sv
module tme_latch_bank
    import tme_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_MODES-1:0] set_vec,
    input  logic                 det_off,
    input  logic                 clear_all,
    output logic [NUM_MODES-1:0] modes
);
    for (genvar i = 0; i < NUM_MODES; i++) begin : g_latch
        logic kill;

        if (i == IDX_PLATE_HI) begin : g_hi
            assign kill = set_vec[IDX_PLATE_LO];
        end else if (i == IDX_PLATE_LO) begin : g_lo
            assign kill = set_vec[IDX_PLATE_HI];
        end else if (i == IDX_DETECT) begin : g_det
            assign kill = det_off;
        end else begin : g_plain
            assign kill = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst || clear_all) begin
                modes[i] <= 1'b0;
            end else if (set_vec[i]) begin
                modes[i] <= 1'b1;
            end else if (kill) begin
                modes[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmode_entry_ctrl.sv
module tmode_entry_ctrl
    import tme_pkg::*;
#(
    parameter int ARM_COUNT = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rst_wr_i,
    input  logic                 wr_en_i,
    input  logic [CODE_W-1:0]    code_i,
    output logic                 entry_en_o,
    output logic [NUM_MODES-1:0] mode_o
);
    tme_state_e            state_q, state_d;
    logic                  arm_pulse;
    logic                  dec_valid;
    logic [NUM_MODES-1:0]  set_vec;
    logic                  det_off, freeze, clear_all;

    tme_arm_counter #(.ARM_COUNT(ARM_COUNT)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .qualify   (rst_wr_i && wr_en_i),
        .arm_pulse (arm_pulse)
    );

    assign dec_valid = (state_q == ST_ENTRY);

    tme_code_decoder u_dec (
        .code      (code_i),
        .valid     (dec_valid),
        .set_vec   (set_vec),
        .det_off   (det_off),
        .freeze    (freeze),
        .clear_all (clear_all)
    );

    tme_latch_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .det_off   (det_off),
        .clear_all (clear_all),
        .modes     (mode_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm_pulse)          state_d = ST_ARMED;
            ST_ARMED: if (!rst_wr_i)          state_d = ST_ENTRY;
            ST_ENTRY: if (freeze || clear_all) state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        entry_en_o = (state_q == ST_ENTRY);
    end

endmodule

// File: rtl/tme_checker.sv
module tme_checker
    import tme_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 rst_wr_i,
    input logic [CODE_W-1:0]    code_i,
    input logic                 entry_en_o,
    input logic [NUM_MODES-1:0] mode_o
);
    assert_plate_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(mode_o[IDX_PLATE_HI] && mode_o[IDX_PLATE_LO]));

    assert_entry_after_low_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(entry_en_o) |-> !$past(rst_wr_i));

    assert_closed_no_change_R10: assert property (@(posedge clk) disable iff (rst)
        !entry_en_o |=> mode_o == $past(mode_o));

    assert_zero_code_idle_R5: assert property (@(posedge clk) disable iff (rst)
        entry_en_o && code_i == CODE_NONE |=> mode_o == $past(mode_o));

    assert_freeze_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        entry_en_o && code_i == CODE_FREEZE |=> !entry_en_o && mode_o == $past(mode_o));

    assert_clear_all_R9: assert property (@(posedge clk) disable iff (rst)
        entry_en_o && code_i == CODE_CLEAR |=> !entry_en_o && mode_o == '0);

    assert_detect_off_R7: assert property (@(posedge clk) disable iff (rst)
        entry_en_o && code_i == CODE_DET_OFF |=> !mode_o[IDX_DETECT]);

    for (genvar i = 0; i < NUM_MODES; i++) begin : g_set
        assert_code_sets_mode_R4: assert property (@(posedge clk) disable iff (rst)
            entry_en_o && code_i == CODE_W'(i + 1) |=> mode_o[i]);
    end

endmodule

bind tmode_entry_ctrl tme_checker u_tme_checker (
    .clk        (clk),
    .rst        (rst),
    .rst_wr_i   (rst_wr_i),
    .code_i     (code_i),
    .entry_en_o (entry_en_o),
    .mode_o     (mode_o)
);

// File: tb/tmode_entry_ctrl_test.sv
module tmode_entry_ctrl_test;
    localparam int ARM = 1024;
    localparam int NM  = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          rst_wr, wr_en;
    logic [3:0]    code;
    logic          entry_en;
    logic [NM-1:0] modes;
    logic [NM-1:0] exp_m;
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;

    always #4 clk = ~clk;

    tmode_entry_ctrl #(.ARM_COUNT(ARM)) uut (
        .clk        (clk),
        .rst        (rst),
        .rst_wr_i   (rst_wr),
        .wr_en_i    (wr_en),
        .code_i     (code),
        .entry_en_o (entry_en),
        .mode_o     (modes)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NM-1:0] model(logic [NM-1:0] m, int c);
        logic [NM-1:0] r = m;
        if (c >= 1 && c <= 12) r[c-1] = 1'b1;
        if (c == 4)  r[4]  = 1'b0;
        if (c == 5)  r[3]  = 1'b0;
        if (c == 13) r[11] = 1'b0;
        if (c == 15) r = '0;
        return r;
    endfunction

    task automatic hold(int n);
        rst_wr = 1'b1; wr_en = 1'b1;
        repeat (n) tick();
    endtask

    task automatic arm_full(string req);
        code = 4'd0;
        hold(ARM);
        chk({req, " closed while reset-write high"}, 32'(entry_en), 0);
        tick();
        chk({req, " still closed one edge later"}, 32'(entry_en), 0);
        rst_wr = 1'b0; wr_en = 1'b0;
        tick();
        chk({req, " entry opens"}, 32'(entry_en), 1);
    endtask

    task automatic enter(int c, string req);
        code = 4'(c);
        tick();
        exp_m = model(exp_m, c);
        chk(req, 32'(modes), 32'(exp_m));
        code = 4'd0;
    endtask

    initial begin
        rst = 1'b1; rst_wr = 1'b0; wr_en = 1'b0; code = 4'd0;
        exp_m = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 entry after reset", 32'(entry_en), 0);
        chk("R1 modes after reset", 32'(modes), 0);

        // R10: code while idle
        code = 4'd1; tick();
        chk("R10 idle code ignored", 32'(modes), 0);
        code = 4'd0;

        // R2: short hold then drop of write-enable alone
        hold(ARM - 1);
        wr_en = 1'b0; tick();
        rst_wr = 1'b0; tick(); tick();
        chk("R2 short hold no arm", 32'(entry_en), 0);
        // R2: two short holds must not add up
        hold(ARM - 1);
        rst_wr = 1'b0; tick();
        hold(2);
        rst_wr = 1'b0; wr_en = 1'b0; tick(); tick();
        chk("R2 split holds no arm", 32'(entry_en), 0);

        // R3 + R4/R5/R6/R7 in one session
        arm_full("R3");
        for (int c = 1; c <= 12; c++) enter(c, "R4 accumulate");
        enter(0,  "R5 code zero");
        enter(4,  "R6 plate high wins");
        enter(5,  "R6 plate low wins");
        enter(13, "R7 detect off");
        chk("R7 detect bit", 32'(modes[11]), 0);

        // R8 freeze, ignored code, re-arm
        enter(14, "R8 freeze keeps modes");
        chk("R8 entry closed", 32'(entry_en), 0);
        code = 4'd12; tick(); code = 4'd0;
        chk("R10 code after freeze ignored", 32'(modes), 32'(exp_m));
        arm_full("R8 rearm");
        chk("R8 modes kept after rearm", 32'(modes), 32'(exp_m));
        enter(12, "R8 add after rearm");

        // R9 clear
        enter(15, "R9 clear");
        chk("R9 entry closed", 32'(entry_en), 0);

        // R4 each code alone in fresh session
        for (int c = 1; c <= 12; c++) begin
            arm_full("R4 session");
            enter(c, "R4 single code");
            chk("R4 single bit", 32'(modes), 32'(1) << (c - 1));
            enter(15, "R9 clear session");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule